// File: doc/BRIEF.md
# Bidirectional Latched Octal Transceiver

This block moves 8-bit words between two ports, A and B. Each direction has its own bank of holding latches and its own three active-low controls: a chip-enable, a latch-enable and an output-enable. Data bound for B is taken in from port A and put out on port B. Data bound for A is taken in from port B and put out on port A. The two directions work independently of each other. A latch bank is open only while its chip-enable and latch-enable are both low. It holds its contents once either of them goes high. The far port is driven only while the chip-enable and the output-enable of that direction are both low.

Each port is modelled as separate input, output and drive-enable signals instead of a true inout pin. An external-drive qualifier on each port input says whether something outside is driving the port. Each port has a keeper register that remembers the last valid level on the bus. That level comes from the external driver when there is one, and otherwise from the block's own output. When neither drives the bus, the latch input sees the kept level. The block reports bus contention on a status output and does not resolve it.

The latch banks are built as flops clocked by a fast system clock that samples the enable conditions. A parameter selects whether an open latch also passes its input straight through in the same cycle (the default) or only after the next clock edge.

Top module: `xcvr_octal_latched`

## Requirements
- R1: While `rst_n` is low, `a_oe` and `b_oe` are 0. After reset, both latch banks hold 0x00.
- R2: While `ab_ce_n`=0 and `ab_le_n`=0, the A-to-B bank is open. In the default pass-through variant, `b_out` follows the A bus value in the same cycle when `b_oe` is 1.
- R3: When `ab_le_n` rises while the A-to-B bank is open, the bank keeps the A value sampled at the last clock edge before the rise. Later changes on A do not reach `b_out`.
- R4: When `ab_ce_n` rises while the A-to-B bank is open, the bank also holds its contents. The held value stays valid after `ab_ce_n` falls again with `ab_le_n` high.
- R5: While `ab_ce_n`=1, `ab_le_n`=0 does not load the A-to-B bank.
- R6: `b_oe` is 1 only when `ab_ce_n`=0 and `ab_oe_n`=0. When `b_oe` is 0, `b_out` reads 0x00. When `b_oe` is 1, `b_out` shows the A-to-B bank.
- R7: The B-to-A direction behaves like R2 to R6, using `ba_ce_n`, `ba_le_n`, `ba_oe_n`, `a_oe` and `a_out`. The A-to-B controls have no effect on port A outputs, and the B-to-A controls have no effect on port B outputs.
- R8: When the external driver of a port is released, that port's keeper (`a_keep`/`b_keep`) keeps the last driven value. An open latch loads the kept value.
- R9: When only the block drives a port, that port's keeper takes the block's output value at the next clock edge.
- R10: When the external drive qualifier and the block's own drive enable of a port are both 1, the port's contention output is 1 in the same cycle, and the keeper does not change at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the latch enables |
| rst_n | input | 1 | Active-low reset |
| a_in | input | 8 | Value an external driver places on port A |
| a_in_drv | input | 1 | 1 when an external driver is driving port A |
| a_out | output | 8 | Value the block drives on port A (0 when not driving) |
| a_oe | output | 1 | 1 when the block drives port A |
| a_keep | output | 8 | Keeper level for port A |
| a_contend | output | 1 | Both the block and an external driver drive port A |
| b_in | input | 8 | Value an external driver places on port B |
| b_in_drv | input | 1 | 1 when an external driver is driving port B |
| b_out | output | 8 | Value the block drives on port B (0 when not driving) |
| b_oe | output | 1 | 1 when the block drives port B |
| b_keep | output | 8 | Keeper level for port B |
| b_contend | output | 1 | Both the block and an external driver drive port B |
| ab_ce_n | input | 1 | A-to-B chip-enable, active low |
| ab_le_n | input | 1 | A-to-B latch-enable, active low |
| ab_oe_n | input | 1 | A-to-B output-enable, active low |
| ba_ce_n | input | 1 | B-to-A chip-enable, active low |
| ba_le_n | input | 1 | B-to-A latch-enable, active low |
| ba_oe_n | input | 1 | B-to-A output-enable, active low |

## Verification
The hardest state to reach is an open latch that loads a value nobody is driving any more. The bench drives port A and lets one clock edge pass so the keeper records the value. It then drops the drive qualifier and puts an unrelated value on `a_in`, and only then opens the A-to-B bank. If `b_out` shows the recorded value, the latch was loaded from the keeper and not from the stale input. Contention is reached by loading the B-to-A bank, enabling its output and then asserting the external driver on port A. The bench checks that the flag is raised in that cycle and that the keeper stays frozen across the following edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   // Active-low control set of one transfer direction
   typedef struct packed {
      logic ce_n;
      logic le_n;
      logic oe_n;
   } dir_ctrl_t;

   // Bank accepts new data while chip and latch enables are both low
   function automatic logic bank_open(input dir_ctrl_t c);
      return (!c.ce_n) && (!c.le_n);
   endfunction

   // Far port is driven while chip and output enables are both low
   function automatic logic drive_on(input dir_ctrl_t c);
      return (!c.ce_n) && (!c.oe_n);
   endfunction

endpackage

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_drv_i,
   input  logic [DATA_W-1:0] ext_val_i,
   input  logic              own_drv_i,
   input  logic [DATA_W-1:0] own_val_i,
   output logic [DATA_W-1:0] keep_o,
   output logic [DATA_W-1:0] view_o,
   output logic              contend_o
);

   if (DATA_W < 1) begin : g_bad_width
      $error("xcvr_keeper: DATA_W must be at least 1");
   end

   logic [DATA_W-1:0] keep_q;
   logic              clash;

   assign clash = ext_drv_i & own_drv_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         keep_q <= '0;
      end else if (clash) begin
         keep_q <= keep_q;          // unknown bus level: leave keeper untouched
      end else if (ext_drv_i) begin
         keep_q <= ext_val_i;
      end else if (own_drv_i) begin
         keep_q <= own_val_i;
      end
   end

   // Latch input sees the outside driver, otherwise the kept level
   assign view_o    = ext_drv_i ? ext_val_i : keep_q;
   assign keep_o    = keep_q;
   assign contend_o = clash;

   AST_KEEP_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_drv_i && !own_drv_i) |=> $stable(keep_o)); // R8
   AST_KEEP_TRACK_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_drv_i && !own_drv_i) |=> (keep_o == $past(ext_val_i))); // R8
   AST_KEEP_TRACK_OWN: assert property (@(posedge clk) disable iff (!rst_n)
      (own_drv_i && !ext_drv_i) |=> (keep_o == $past(own_val_i))); // R9
   AST_KEEP_CONTEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      contend_o |=> $stable(keep_o)); // R10

endmodule

// File: rtl/xcvr_latch_bank.sv
module xcvr_latch_bank
   import xcvr_pkg::*;
#(
   parameter int DATA_W             = 8,
   parameter bit TRANSPARENT_BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dir_ctrl_t         ctrl_i,
   input  logic [DATA_W-1:0] din_i,
   output logic [DATA_W-1:0] dout_o
);

   if (DATA_W < 1) begin : g_bad_width
      $error("xcvr_latch_bank: DATA_W must be at least 1");
   end

   logic              open_w;
   logic [DATA_W-1:0] store_q;

   assign open_w = bank_open(ctrl_i);

   // Level-sensitive latch emulated by a flop sampling at the system clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store_q <= '0;
      end else if (open_w) begin
         store_q <= din_i;
      end
   end

   if (TRANSPARENT_BYPASS) begin : g_bypass
      // Open bank passes its input through in the same cycle
      assign dout_o = open_w ? din_i : store_q;

      AST_OPEN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         open_w |-> (dout_o == din_i)); // R2
   end else begin : g_registered
      // Open bank shows its input after the next clock edge
      assign dout_o = store_q;

      AST_OPEN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         open_w |=> (dout_o == $past(din_i))); // R2
   end

   AST_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_w) |=> (open_w || $stable(dout_o))); // R3
   AST_CE_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_i.ce_n && $past(ctrl_i.ce_n)) |-> $stable(dout_o)); // R5

endmodule

// File: rtl/xcvr_port_drive.sv
module xcvr_port_drive
   import xcvr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dir_ctrl_t         ctrl_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              oe_o,
   output logic [DATA_W-1:0] dout_o
);

   if (DATA_W < 1) begin : g_bad_width
      $error("xcvr_port_drive: DATA_W must be at least 1");
   end

   logic drive_w;

   // No drive at all while reset is asserted
   assign drive_w = rst_n & drive_on(ctrl_i);
   assign oe_o    = drive_w;
   assign dout_o  = drive_w ? data_i : '0;

   AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
      oe_o |-> (!ctrl_i.ce_n && !ctrl_i.oe_n)); // R6
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_o) |-> (dout_o == '0)); // R6

   always_comb begin
      if (!rst_n) begin
         AST_NO_DRIVE_IN_RESET: assert (!oe_o); // R1
      end
   end

endmodule

// File: rtl/xcvr_octal_latched.sv
module xcvr_octal_latched
   import xcvr_pkg::*;
#(
   parameter int DATA_W             = 8,
   parameter bit TRANSPARENT_BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] a_in,
   input  logic              a_in_drv,
   output logic [DATA_W-1:0] a_out,
   output logic              a_oe,
   output logic [DATA_W-1:0] a_keep,
   output logic              a_contend,
   input  logic [DATA_W-1:0] b_in,
   input  logic              b_in_drv,
   output logic [DATA_W-1:0] b_out,
   output logic              b_oe,
   output logic [DATA_W-1:0] b_keep,
   output logic              b_contend,
   input  logic              ab_ce_n,
   input  logic              ab_le_n,
   input  logic              ab_oe_n,
   input  logic              ba_ce_n,
   input  logic              ba_le_n,
   input  logic              ba_oe_n
);

   if (DATA_W < 1) begin : g_bad_width
      $error("xcvr_octal_latched: DATA_W must be at least 1");
   end

   dir_ctrl_t         ab_ctrl, ba_ctrl;
   logic [DATA_W-1:0] a_view, b_view;
   logic [DATA_W-1:0] ab_data, ba_data;

   assign ab_ctrl = '{ce_n: ab_ce_n, le_n: ab_le_n, oe_n: ab_oe_n};
   assign ba_ctrl = '{ce_n: ba_ce_n, le_n: ba_le_n, oe_n: ba_oe_n};

   // Port keepers: the latch inputs read the kept level, never the block's own
   // output directly, so there is no combinational path around the two banks
   xcvr_keeper #(.DATA_W(DATA_W)) u_keep_a (
      .clk(clk), .rst_n(rst_n),
      .ext_drv_i(a_in_drv), .ext_val_i(a_in),
      .own_drv_i(a_oe), .own_val_i(a_out),
      .keep_o(a_keep), .view_o(a_view), .contend_o(a_contend)
   );

   xcvr_keeper #(.DATA_W(DATA_W)) u_keep_b (
      .clk(clk), .rst_n(rst_n),
      .ext_drv_i(b_in_drv), .ext_val_i(b_in),
      .own_drv_i(b_oe), .own_val_i(b_out),
      .keep_o(b_keep), .view_o(b_view), .contend_o(b_contend)
   );

   // A-to-B direction
   xcvr_latch_bank #(.DATA_W(DATA_W), .TRANSPARENT_BYPASS(TRANSPARENT_BYPASS)) u_bank_ab (
      .clk(clk), .rst_n(rst_n), .ctrl_i(ab_ctrl), .din_i(a_view), .dout_o(ab_data)
   );

   xcvr_port_drive #(.DATA_W(DATA_W)) u_drive_b (
      .clk(clk), .rst_n(rst_n), .ctrl_i(ab_ctrl), .data_i(ab_data),
      .oe_o(b_oe), .dout_o(b_out)
   );

   // B-to-A direction
   xcvr_latch_bank #(.DATA_W(DATA_W), .TRANSPARENT_BYPASS(TRANSPARENT_BYPASS)) u_bank_ba (
      .clk(clk), .rst_n(rst_n), .ctrl_i(ba_ctrl), .din_i(b_view), .dout_o(ba_data)
   );

   xcvr_port_drive #(.DATA_W(DATA_W)) u_drive_a (
      .clk(clk), .rst_n(rst_n), .ctrl_i(ba_ctrl), .data_i(ba_data),
      .oe_o(a_oe), .dout_o(a_out)
   );

   AST_A_CONTEND_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      a_contend |-> (a_in_drv && !ba_ce_n && !ba_oe_n)); // R10
   AST_B_CONTEND_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      b_contend |-> (b_in_drv && !ab_ce_n && !ab_oe_n)); // R10
   AST_A_SIDE_INDEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ba_ce_n || ba_oe_n) |-> (!a_oe)); // R7

endmodule

// File: tb/xcvr_octal_latched_tb.sv
module xcvr_octal_latched_tb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] a_in, b_in;
   logic       a_in_drv, b_in_drv;
   logic [7:0] a_out, b_out, a_keep, b_keep;
   logic       a_oe, b_oe, a_contend, b_contend;
   logic       ab_ce_n, ab_le_n, ab_oe_n, ba_ce_n, ba_le_n, ba_oe_n;

   int n_checks = 0;
   int n_errors = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   xcvr_octal_latched u_dut (
      .clk(clk), .rst_n(rst_n),
      .a_in(a_in), .a_in_drv(a_in_drv), .a_out(a_out), .a_oe(a_oe),
      .a_keep(a_keep), .a_contend(a_contend),
      .b_in(b_in), .b_in_drv(b_in_drv), .b_out(b_out), .b_oe(b_oe),
      .b_keep(b_keep), .b_contend(b_contend),
      .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
      .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n)
   );

   // Output-gating table: {ab_ce_n, ab_oe_n, ba_ce_n, ba_oe_n, exp_b_oe, exp_a_oe}
   localparam logic [5:0] GATE_TAB [8] = '{
      6'b0000_11, 6'b0100_01, 6'b1000_01, 6'b1100_01,
      6'b0011_10, 6'b0001_10, 6'b0010_10, 6'b1111_00
   };

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic all_idle();
      ab_ce_n = 1; ab_le_n = 1; ab_oe_n = 1;
      ba_ce_n = 1; ba_le_n = 1; ba_oe_n = 1;
   endtask

   initial begin
      #500us;
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      rst_n = 0; a_in = 0; b_in = 0; a_in_drv = 0; b_in_drv = 0;
      all_idle();
      step(); step();
      // R1: no drive during reset even with enables asserted
      ab_ce_n = 0; ab_oe_n = 0; ba_ce_n = 0; ba_oe_n = 0;
      #1;
      check("R1 b_oe in reset", {7'd0, b_oe}, 8'd0);
      check("R1 a_oe in reset", {7'd0, a_oe}, 8'd0);
      step();
      rst_n = 1;
      #1;
      check("R1 b_out after reset", b_out, 8'h00);
      check("R1 a_out after reset", a_out, 8'h00);
      all_idle();
      step();

      // R2: open A-to-B bank follows A
      a_in_drv = 1; a_in = 8'hA5;
      ab_ce_n = 0; ab_le_n = 0; ab_oe_n = 0;
      #1;
      check("R2 follow A5", b_out, 8'hA5);
      a_in = 8'h3C;
      #1;
      check("R2 follow 3C", b_out, 8'h3C);
      step();
      // R3: le_n rise holds
      ab_le_n = 1; a_in = 8'hFF;
      #1;
      check("R3 hold after le rise", b_out, 8'h3C);
      step();
      check("R3 hold next cycle", b_out, 8'h3C);

      // R4: ce_n rise holds
      ab_le_n = 0; a_in = 8'h81;
      step();
      ab_ce_n = 1;
      #1;
      check("R6 b_out zero when ce high", b_out, 8'h00);
      check("R6 b_oe low when ce high", {7'd0, b_oe}, 8'd0);
      a_in = 8'h00;
      step();
      ab_le_n = 1; ab_ce_n = 0;
      #1;
      check("R4 hold after ce rise", b_out, 8'h81);

      // R5: le_n low with ce_n high does not load
      ab_ce_n = 1; ab_le_n = 0; a_in = 8'h77;
      step(); step();
      ab_le_n = 1; ab_ce_n = 0;
      #1;
      check("R5 no load with ce high", b_out, 8'h81);
      a_in_drv = 0;
      all_idle();
      step();

      // Load B-to-A bank with 5A
      b_in_drv = 1; b_in = 8'h5A;
      ba_ce_n = 0; ba_le_n = 0;
      step();
      ba_le_n = 1; b_in_drv = 0; b_in = 8'h00;
      all_idle();
      step();

      // R6/R7: output gating table walk
      foreach (GATE_TAB[i]) begin
         {ab_ce_n, ab_oe_n, ba_ce_n, ba_oe_n} = GATE_TAB[i][5:2];
         #1;
         check($sformatf("R6 b_oe row %0d", i), {7'd0, b_oe}, {7'd0, GATE_TAB[i][1]});
         check($sformatf("R6 b_out row %0d", i), b_out, GATE_TAB[i][1] ? 8'h81 : 8'h00);
         check($sformatf("R7 a_oe row %0d", i), {7'd0, a_oe}, {7'd0, GATE_TAB[i][0]});
         check($sformatf("R7 a_out row %0d", i), a_out, GATE_TAB[i][0] ? 8'h5A : 8'h00);
         check($sformatf("R10 no contention row %0d", i), {6'd0, a_contend, b_contend}, 8'd0);
         step();
      end
      all_idle();
      step();

      // R8: keeper holds released value; open latch loads it
      a_in_drv = 1; a_in = 8'h66;
      step();
      a_in_drv = 0; a_in = 8'h11;
      #1;
      check("R8 keeper after release", a_keep, 8'h66);
      ab_ce_n = 0; ab_le_n = 0; ab_oe_n = 0;
      #1;
      check("R8 latch sees keeper", b_out, 8'h66);
      step();
      ab_le_n = 1;
      #1;
      check("R8 latch captured keeper", b_out, 8'h66);
      check("R8 keeper still held", a_keep, 8'h66);
      all_idle();
      step();

      // R9: keeper tracks block's own drive
      ba_ce_n = 0; ba_oe_n = 0;
      step();
      check("R9 keeper tracks own drive", a_keep, 8'h5A);
      ba_ce_n = 1;
      step();
      check("R9 keeper holds after release", a_keep, 8'h5A);

      // R10: contention on port A
      ba_ce_n = 0; ba_oe_n = 0; a_in_drv = 1; a_in = 8'h0F;
      #1;
      check("R10 a_contend raised", {7'd0, a_contend}, 8'd1);
      check("R10 b_contend quiet", {7'd0, b_contend}, 8'd0);
      step();
      check("R10 keeper frozen under contention", a_keep, 8'h5A);
      a_in_drv = 0;
      #1;
      check("R10 a_contend cleared", {7'd0, a_contend}, 8'd0);
      all_idle();
      // R10: contention on port B
      ab_ce_n = 0; ab_oe_n = 0; b_in_drv = 1; b_in = 8'hC3;
      #1;
      check("R10 b_contend raised", {7'd0, b_contend}, 8'd1);
      check("R10 a_contend quiet", {7'd0, a_contend}, 8'd0);
      b_in_drv = 0;
      all_idle();
      step();

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule